// File: doc/BRIEF.md
# Flash Overlay Emulation Remapper

This block sits on the address path between a processor and the on-chip flash and RAM. While its overlay is switched on, reads and writes aimed at one chosen small flash block are steered into a fixed 4 KB RAM window. Calibration data can then be adjusted live in RAM and written to flash later. The flash side of the overlay follows a 3-bit block selector. The RAM side always stays at the same window, and that window also answers at its own RAM address.

A control register holds the overlay switch and the block selector. Address decoding is purely combinational. It produces a flash chip select, a RAM chip select and the translated memory address. Program and erase requests from the flash controller pass through a gate. The gate reports a program or erase mode only while the overlay is off. With the overlay on, every flash block is locked against program and erase, whichever block is selected. This also keeps the emulation RAM out of reach of any erase.

Top module: `flash_overlay_remap`

## Requirements
- R1: An active-low asynchronous reset clears the overlay switch and the block selector. Register readback is then 0x00 and flash addresses reach the flash array.
- R2: A control write stores data bit 7 as the overlay switch and data bits 2:0 as the block selector. Readback shows those bits in the same positions and zero in bits 6:3. The new value governs the outputs from the cycle after the write strobe. During the write cycle itself, the old value still applies.
- R3: With the switch off, any requested address below 0x40000 asserts the flash select only. The memory address then equals the bus address, whatever the selector holds.
- R4: With the switch on and selector n (0 to 7), addresses 0x1000·n to 0x1000·n+0xFFF assert the RAM select only. The memory address becomes 0xFFD000 plus the low 12 bus address bits.
- R5: With the switch on, flash addresses outside the selected block still assert the flash select, with the address unchanged.
- R6: Addresses at or above 0x08000 are never redirected. For them, the memory address always equals the bus address.
- R7: Addresses from 0xFFD000 to 0xFFEFBF assert the RAM select with the address unchanged, whether the switch is on or off.
- R8: An address outside both the flash and RAM ranges asserts neither select.
- R9: While the switch is on, neither program mode nor erase mode is reported, whatever the selector holds.
- R10: With the switch off, a program request alone reports program mode and an erase request alone reports erase mode. Both requests together report neither.
- R11: With no bus request, neither chip select is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data (bit 7 switch, bits 2:0 selector) |
| ctl_rdata | output | 8 | Control register readback |
| bus_req | input | 1 | Bus access valid |
| bus_addr | input | 24 | Bus byte address |
| flash_cs | output | 1 | Flash array select |
| ram_cs | output | 1 | RAM select |
| mem_addr | output | 24 | Translated memory address |
| pgm_req | input | 1 | Program request from flash control |
| ers_req | input | 1 | Erase request from flash control |
| mode_prog | output | 1 | Program mode granted |
| mode_erase | output | 1 | Erase mode granted |

## Verification
A control write and a bus access, or a program request, can happen in the same cycle. The write then changes both the redirect and the program/erase lock, but only from the next cycle on. The bench holds an address inside the block about to be selected, with a program request active, and strobes a write that turns the overlay on. It checks that the write cycle still shows a flash select and program mode, and that the following cycle shows the RAM window address with program mode withdrawn. The reverse write then restores both together.

// File: rtl/ovr_pkg.sv
package ovr_pkg;

   typedef enum logic [1:0] {
      PE_IDLE  = 2'd0,
      PE_PROG  = 2'd1,
      PE_ERASE = 2'd2
   } pe_mode_e;

   function automatic pe_mode_e pe_resolve(input logic lock, input logic p, input logic e);
      if (lock || (p == e)) return PE_IDLE;
      else if (p)           return PE_PROG;
      else                  return PE_ERASE;
   endfunction

endpackage

// File: rtl/ovr_ctl_reg.sv
module ovr_ctl_reg #(
   parameter int DATA_W = 8,
   parameter int SEL_W  = 3,
   parameter int EN_BIT = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output logic              en,
   output logic [SEL_W-1:0]  sel,
   output logic [DATA_W-1:0] rdata
);

   if (EN_BIT < SEL_W || EN_BIT >= DATA_W) begin : g_bad_en_bit
      $error("ovr_ctl_reg: EN_BIT must sit above the selector and inside the data word");
   end

   logic unused_wdata;
   assign unused_wdata = ^wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en  <= 1'b0;
         sel <= '0;
      end else if (we) begin
         en  <= wdata[EN_BIT];
         sel <= wdata[SEL_W-1:0];
      end
   end

   always_comb begin
      rdata              = '0;
      rdata[EN_BIT]      = en;
      rdata[SEL_W-1:0]   = sel;
   end

endmodule

// File: rtl/ovr_addr_map.sv
module ovr_addr_map #(
   parameter int          ADDR_W      = 24,
   parameter int          BLK_AW      = 12,
   parameter int          NUM_BLK     = 8,
   parameter int unsigned FLASH_BYTES = 32'h40000,
   parameter int unsigned RAM_LO      = 32'hFFD000,
   parameter int unsigned RAM_HI      = 32'hFFEFBF,
   localparam int         SEL_W       = $clog2(NUM_BLK)
) (
   input  logic              req,
   input  logic [ADDR_W-1:0] addr,
   input  logic              en,
   input  logic [SEL_W-1:0]  sel,
   output logic              flash_cs,
   output logic              ram_cs,
   output logic [ADDR_W-1:0] mem_addr
);

   localparam int                BLK_W     = ADDR_W - BLK_AW;
   localparam logic [ADDR_W:0]   FLASH_END = (ADDR_W+1)'(FLASH_BYTES);
   localparam logic [ADDR_W-1:0] RAM_LO_V  = ADDR_W'(RAM_LO);
   localparam logic [ADDR_W-1:0] RAM_HI_V  = ADDR_W'(RAM_HI);
   localparam logic [BLK_W-1:0]  WIN_TAG   = RAM_LO_V[ADDR_W-1:BLK_AW];

   if (RAM_LO_V[BLK_AW-1:0] != '0) begin : g_bad_align
      $error("ovr_addr_map: RAM window base must be block aligned");
   end
   if (RAM_LO + (32'd1 << BLK_AW) - 1 > RAM_HI) begin : g_bad_fit
      $error("ovr_addr_map: RAM window does not fit inside RAM");
   end
   if ((NUM_BLK << BLK_AW) > FLASH_BYTES) begin : g_bad_flash
      $error("ovr_addr_map: small blocks exceed the flash size");
   end

   logic [NUM_BLK-1:0] blk_hit;
   logic [NUM_BLK-1:0] sel_dec;

   for (genvar i = 0; i < NUM_BLK; i++) begin : g_blk
      assign blk_hit[i] = (addr[ADDR_W-1:BLK_AW] == BLK_W'(i));
      assign sel_dec[i] = (sel == SEL_W'(i));
   end

   logic redirect;
   logic in_flash;
   logic in_ram;

   assign redirect = en && |(blk_hit & sel_dec);
   assign in_flash = ({1'b0, addr} < FLASH_END);
   assign in_ram   = (addr >= RAM_LO_V) && (addr <= RAM_HI_V);

   assign flash_cs = req && in_flash && !redirect;
   assign ram_cs   = req && (in_ram || redirect);
   assign mem_addr = redirect ? {WIN_TAG, addr[BLK_AW-1:0]} : addr;

endmodule

// File: rtl/ovr_pe_gate.sv
module ovr_pe_gate
   import ovr_pkg::*;
(
   input  logic lock,
   input  logic p_req,
   input  logic e_req,
   output logic mode_prog,
   output logic mode_erase
);

   pe_mode_e mode;

   assign mode       = pe_resolve(lock, p_req, e_req);
   assign mode_prog  = (mode == PE_PROG);
   assign mode_erase = (mode == PE_ERASE);

endmodule

// File: rtl/flash_overlay_remap.sv
module flash_overlay_remap #(
   parameter int          ADDR_W      = 24,
   parameter int          DATA_W      = 8,
   parameter int          BLK_AW      = 12,
   parameter int          NUM_BLK     = 8,
   parameter int          EN_BIT      = 7,
   parameter int unsigned FLASH_BYTES = 32'h40000,
   parameter int unsigned RAM_LO      = 32'hFFD000,
   parameter int unsigned RAM_HI      = 32'hFFEFBF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_we,
   input  logic [DATA_W-1:0] ctl_wdata,
   output logic [DATA_W-1:0] ctl_rdata,
   input  logic              bus_req,
   input  logic [ADDR_W-1:0] bus_addr,
   output logic              flash_cs,
   output logic              ram_cs,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              pgm_req,
   input  logic              ers_req,
   output logic              mode_prog,
   output logic              mode_erase
);

   localparam int SEL_W = $clog2(NUM_BLK);

   if (NUM_BLK < 2 || (1 << SEL_W) != NUM_BLK) begin : g_bad_blk
      $error("flash_overlay_remap: NUM_BLK must be a power of two, at least 2");
   end
   if (ADDR_W > 31 || BLK_AW >= ADDR_W) begin : g_bad_aw
      $error("flash_overlay_remap: address widths out of range");
   end

   logic             ovl_en;
   logic [SEL_W-1:0] ovl_sel;

   ovr_ctl_reg #(
      .DATA_W (DATA_W),
      .SEL_W  (SEL_W),
      .EN_BIT (EN_BIT)
   ) u_ctl (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (ctl_we),
      .wdata (ctl_wdata),
      .en    (ovl_en),
      .sel   (ovl_sel),
      .rdata (ctl_rdata)
   );

   ovr_addr_map #(
      .ADDR_W      (ADDR_W),
      .BLK_AW      (BLK_AW),
      .NUM_BLK     (NUM_BLK),
      .FLASH_BYTES (FLASH_BYTES),
      .RAM_LO      (RAM_LO),
      .RAM_HI      (RAM_HI)
   ) u_map (
      .req      (bus_req),
      .addr     (bus_addr),
      .en       (ovl_en),
      .sel      (ovl_sel),
      .flash_cs (flash_cs),
      .ram_cs   (ram_cs),
      .mem_addr (mem_addr)
   );

   ovr_pe_gate u_gate (
      .lock       (ovl_en),
      .p_req      (pgm_req),
      .e_req      (ers_req),
      .mode_prog  (mode_prog),
      .mode_erase (mode_erase)
   );

endmodule

// File: rtl/ovr_remap_chk.sv
module ovr_remap_chk #(
   parameter int ADDR_W  = 24,
   parameter int DATA_W  = 8,
   parameter int BLK_AW  = 12,
   parameter int NUM_BLK = 8,
   parameter int EN_BIT  = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ctl_we,
   input logic [DATA_W-1:0] ctl_wdata,
   input logic [DATA_W-1:0] ctl_rdata,
   input logic              bus_req,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              flash_cs,
   input logic              ram_cs,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              pgm_req,
   input logic              ers_req,
   input logic              mode_prog,
   input logic              mode_erase
);

   localparam logic [ADDR_W:0] SMALL_END = (ADDR_W+1)'(NUM_BLK) << BLK_AW;

   // R2
   ctl_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_we |=> ctl_rdata[EN_BIT] == $past(ctl_wdata[EN_BIT]));

   // R9
   pe_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_rdata[EN_BIT] |-> (!mode_prog && !mode_erase));

   // R10
   pe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pgm_req && ers_req) |-> (!mode_prog && !mode_erase));

   // R4
   cs_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(flash_cs && ram_cs));

   // R4
   low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ram_cs |-> (mem_addr[BLK_AW-1:0] == bus_addr[BLK_AW-1:0]));

   // R6
   high_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, bus_addr} >= SMALL_END) |-> (mem_addr == bus_addr));

   // R11
   idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_req |-> (!flash_cs && !ram_cs));

endmodule

bind flash_overlay_remap ovr_remap_chk #(
   .ADDR_W  (ADDR_W),
   .DATA_W  (DATA_W),
   .BLK_AW  (BLK_AW),
   .NUM_BLK (NUM_BLK),
   .EN_BIT  (EN_BIT)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ctl_we     (ctl_we),
   .ctl_wdata  (ctl_wdata),
   .ctl_rdata  (ctl_rdata),
   .bus_req    (bus_req),
   .bus_addr   (bus_addr),
   .flash_cs   (flash_cs),
   .ram_cs     (ram_cs),
   .mem_addr   (mem_addr),
   .pgm_req    (pgm_req),
   .ers_req    (ers_req),
   .mode_prog  (mode_prog),
   .mode_erase (mode_erase)
);

// File: tb/flash_overlay_remap_test.sv
module flash_overlay_remap_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctl_we = 1'b0;
   logic [7:0]  ctl_wdata = '0;
   logic [7:0]  ctl_rdata;
   logic        bus_req = 1'b0;
   logic [23:0] bus_addr = '0;
   logic        flash_cs, ram_cs;
   logic [23:0] mem_addr;
   logic        pgm_req = 1'b0, ers_req = 1'b0;
   logic        mode_prog, mode_erase;

   int compared = 0;
   int mismatched = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   flash_overlay_remap uut (
      .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
      .ctl_rdata(ctl_rdata), .bus_req(bus_req), .bus_addr(bus_addr),
      .flash_cs(flash_cs), .ram_cs(ram_cs), .mem_addr(mem_addr),
      .pgm_req(pgm_req), .ers_req(ers_req),
      .mode_prog(mode_prog), .mode_erase(mode_erase)
   );

   // ctl[61:54] addr[53:30] p[29] e[28] fcs[27] rcs[26] maddr[25:2] mp[1] me[0]
   localparam int NV = 16;
   localparam logic [61:0] VEC [NV] = '{
      {8'h00, 24'h000123, 1'b0, 1'b0, 1'b1, 1'b0, 24'h000123, 1'b0, 1'b0}, // R3
      {8'h00, 24'h007FFF, 1'b1, 1'b0, 1'b1, 1'b0, 24'h007FFF, 1'b1, 1'b0}, // R3 R10
      {8'h00, 24'hFFD010, 1'b0, 1'b1, 1'b0, 1'b1, 24'hFFD010, 1'b0, 1'b1}, // R7 R10
      {8'h00, 24'h001000, 1'b1, 1'b1, 1'b1, 1'b0, 24'h001000, 1'b0, 1'b0}, // R10 both
      {8'h80, 24'h000ABC, 1'b1, 1'b0, 1'b0, 1'b1, 24'hFFDABC, 1'b0, 1'b0}, // R4 R9
      {8'h80, 24'h001ABC, 1'b0, 1'b1, 1'b1, 1'b0, 24'h001ABC, 1'b0, 1'b0}, // R5 R9
      {8'h83, 24'h003FFF, 1'b0, 1'b0, 1'b0, 1'b1, 24'hFFDFFF, 1'b0, 1'b0}, // R4
      {8'h83, 24'h003000, 1'b1, 1'b0, 1'b0, 1'b1, 24'hFFD000, 1'b0, 1'b0}, // R4 R9
      {8'h83, 24'h000000, 1'b0, 1'b0, 1'b1, 1'b0, 24'h000000, 1'b0, 1'b0}, // R5
      {8'h87, 24'h007800, 1'b0, 1'b0, 1'b0, 1'b1, 24'hFFD800, 1'b0, 1'b0}, // R4
      {8'h87, 24'h008800, 1'b0, 1'b0, 1'b1, 1'b0, 24'h008800, 1'b0, 1'b0}, // R6
      {8'h87, 24'hFFD234, 1'b0, 1'b0, 1'b0, 1'b1, 24'hFFD234, 1'b0, 1'b0}, // R7
      {8'h87, 24'h040000, 1'b0, 1'b1, 1'b0, 1'b0, 24'h040000, 1'b0, 1'b0}, // R8 R9
      {8'h05, 24'h005004, 1'b1, 1'b0, 1'b1, 1'b0, 24'h005004, 1'b1, 1'b0}, // R3 R10
      {8'hFD, 24'h005004, 1'b0, 1'b0, 1'b0, 1'b1, 24'hFFD004, 1'b0, 1'b0}, // R2 R4
      {8'h80, 24'h03FFFF, 1'b0, 1'b0, 1'b1, 1'b0, 24'h03FFFF, 1'b0, 1'b0}  // R5
   };

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic ctl_write(input logic [7:0] d);
      @(negedge clk);
      ctl_we = 1'b1;
      ctl_wdata = d;
      @(negedge clk);
      ctl_we = 1'b0;
   endtask

   task automatic drive(input logic [23:0] a, input logic p, input logic e);
      bus_req = 1'b1;
      bus_addr = a;
      pgm_req = p;
      ers_req = e;
      #5;
   endtask

   task automatic summary;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         compared++;
         mismatched++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
      end
   end

   initial begin
      // R1 reset state
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      drive(24'h000010, 1'b1, 1'b0);
      chk("R1", "rdata", 32'(ctl_rdata), 32'h00);
      chk("R1", "flash_cs", 32'(flash_cs), 32'h1);
      chk("R1", "mem_addr", 32'(mem_addr), 32'h000010);
      chk("R1", "mode_prog", 32'(mode_prog), 32'h1);

      // table walk
      for (int i = 0; i < NV; i++) begin
         ctl_write(VEC[i][61:54]);
         drive(VEC[i][53:30], VEC[i][29], VEC[i][28]);
         chk("R2", "rdata", 32'(ctl_rdata), 32'(VEC[i][61:54] & 8'h87));
         chk("R3-map", "flash_cs", 32'(flash_cs), 32'(VEC[i][27]));
         chk("R4-map", "ram_cs", 32'(ram_cs), 32'(VEC[i][26]));
         chk("R4-map", "mem_addr", 32'(mem_addr), 32'(VEC[i][25:2]));
         chk("R9/R10", "mode_prog", 32'(mode_prog), 32'(VEC[i][1]));
         chk("R9/R10", "mode_erase", 32'(mode_erase), 32'(VEC[i][0]));
      end

      // R11 no request, overlay still on (sel 0)
      @(negedge clk);
      bus_req = 1'b0;
      bus_addr = 24'h000100;
      #5;
      chk("R11", "flash_cs", 32'(flash_cs), 32'h0);
      chk("R11", "ram_cs", 32'(ram_cs), 32'h0);

      // R2 same-cycle: write and access coincide
      ctl_write(8'h00);
      @(negedge clk);
      drive(24'h002100, 1'b1, 1'b0);
      ctl_we = 1'b1;
      ctl_wdata = 8'h82;
      #1;
      chk("R2", "flash_cs in write cycle", 32'(flash_cs), 32'h1);
      chk("R2", "mode_prog in write cycle", 32'(mode_prog), 32'h1);
      @(negedge clk);
      ctl_we = 1'b0;
      #5;
      chk("R2", "ram_cs after write", 32'(ram_cs), 32'h1);
      chk("R4", "mem_addr after write", 32'(mem_addr), 32'hFFD100);
      chk("R9", "mode_prog after write", 32'(mode_prog), 32'h0);
      ctl_write(8'h02);
      #5;
      chk("R10", "mode_prog after release", 32'(mode_prog), 32'h1);
      chk("R3", "flash_cs after release", 32'(flash_cs), 32'h1);

      // R1 reset during active overlay
      ctl_write(8'h81);
      drive(24'h001234, 1'b0, 1'b0);
      chk("R4", "ram_cs before reset", 32'(ram_cs), 32'h1);
      rst_n = 1'b0;
      #2;
      chk("R1", "rdata in reset", 32'(ctl_rdata), 32'h00);
      chk("R1", "flash_cs in reset", 32'(flash_cs), 32'h1);
      @(negedge clk);
      rst_n = 1'b1;

      done = 1'b1;
      summary();
   end

endmodule